// File: doc/BRIEF.md
# Row/Column Decoded Word Memory

A synchronous behavioural memory that keeps its contents as a physical grid of rows rather than as a flat list of words. In the default organisation it holds 1024 words of 16 bits in 256 rows, with four words side by side in every 64-bit row. The address is split in two. A row decoder turns the upper part into a one-hot set of word lines. A column decoder turns the lower part into a one-hot select that picks one word inside the active row.

An access is sampled on the rising clock edge whenever chip select is high. The read/write select gives the direction: high reads and low writes. Read data is registered and driven onto a tri-stateable data output one clock after the access is sampled. A companion enable output shows when that output is driven. The word lines and column selects are brought out as ports so that the decode can be observed. A parameter switches the block to a narrow 4096 x 1 organisation with a 64 x 64 grid.

Top module: `grid_word_mem`

## Requirements
- R1: In the default organisation, address bits [9:2] select one of 256 rows, and bits [1:0] select one of the four 16-bit words in that row.
- R2: While chip select is high, exactly one word line is high: the one whose index equals the row field of the current address. Word lines follow the inputs combinationally.
- R3: While chip select is high, exactly one column select is high: the one whose index equals the column field of the current address.
- R4: While chip select is low, all word lines and column selects are low. No write takes place, whatever the read/write select and input data are. In the cycle after such an edge, the output enable is low.
- R5: A read (chip select high, read/write high) sampled at a clock edge drives the addressed word onto the data output with the output enable high, starting right after that edge.
- R6: A write (chip select high, read/write low) stores the input data in the addressed word. In the cycle after that edge the output enable is low and the data output is high impedance.
- R7: A write changes only the addressed word. The other words sharing its row keep their values.
- R8: During and right after reset, the output enable is low.
- R9: A read returns the most recently written value of its address, and a read does not change the stored contents.
- R10: With the narrow organisation selected, the block is 4096 x 1. Address bits [11:6] select one of 64 rows, and bits [5:0] select one of 64 single-bit columns. Reads and writes behave as for the default organisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select; high enables an access |
| rw | input | 1 | Direction: high reads, low writes |
| addr | input | AW (10) | Word address: row field above column field |
| din | input | WB (16) | Write data |
| dout | output | WB (16) | Registered read data, high impedance when not driven |
| dout_oe | output | 1 | High while dout is driven |
| word_lines | output | ROWS (256) | One-hot row decode |
| col_sel | output | COLS (4) | One-hot column decode |

## Verification
The assertions take for granted that the address bits are never unknown while chip select is high. They also assume that reset is released away from an access edge. The decode checks rely on chip select alone, so they apply whatever the read/write select is. The bench drives every input on the falling clock edge from fully defined random values, and lets reset release before the first access. It fills the whole array with writes before any random read, so every read returns a defined word.

// File: rtl/wmem_pkg.sv
package wmem_pkg;
  // Organisation helpers: narrow selects the 4096 x 1 grid
  function automatic int row_bits(bit narrow);
    return narrow ? 6 : 8;
  endfunction

  function automatic int col_bits(bit narrow);
    return narrow ? 6 : 2;
  endfunction

  function automatic int word_bits(bit narrow);
    return narrow ? 1 : 16;
  endfunction
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int IW = 8,
  localparam int OW = 1 << IW
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [OW-1:0] lines
);
  always_comb begin
    lines = '0;
    if (en) lines[idx] = 1'b1;
  end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int ROWS = 256,
  parameter int COLS = 4,
  parameter int WB   = 16,
  localparam int ROW_W = COLS * WB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ROWS-1:0] wl,
  input  logic [COLS-1:0] csel,
  input  logic [WB-1:0]   din,
  output logic [WB-1:0]   rd_word
);
  logic [ROW_W-1:0] grid [ROWS];
  logic [ROW_W-1:0] row_bus;   // selected row, as seen after the word lines

  // write: only the column group under an active word line and column select
  always_ff @(posedge clk) begin
    if (we) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (wl[r] && csel[c]) grid[r][c*WB +: WB] <= din;
        end
      end
    end
  end

  // read: wired-OR of rows gated by word lines, then column select
  always_comb begin
    row_bus = '0;
    for (int r = 0; r < ROWS; r++) row_bus |= grid[r] & {ROW_W{wl[r]}};
    rd_word = '0;
    for (int c = 0; c < COLS; c++) rd_word |= row_bus[c*WB +: WB] & {WB{csel[c]}};
  end

  // R2: a write never lands on zero or several rows
  a_r2_write_one_row: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(wl) == 1 && $countones(csel) == 1));
endmodule

// File: rtl/read_port.sv
module read_port #(
  parameter int WB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [WB-1:0] acc_word,
  output wire  [WB-1:0] dout,
  output logic          dout_oe
);
  logic [WB-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_en;
      if (rd_en) q <= acc_word;
    end
  end

  assign dout = dout_oe ? q : {WB{1'bz}};

  // R5: a sampled read is presented one clock later
  a_r5_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (dout_oe && q == $past(acc_word)));
  // R6, R4: anything but a read releases the output
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !dout_oe);
endmodule

// File: rtl/grid_word_mem.sv
module grid_word_mem #(
  parameter bit NARROW = 1'b0,
  localparam int RB   = wmem_pkg::row_bits(NARROW),
  localparam int CB   = wmem_pkg::col_bits(NARROW),
  localparam int WB   = wmem_pkg::word_bits(NARROW),
  localparam int AW   = RB + CB,
  localparam int ROWS = 1 << RB,
  localparam int COLS = 1 << CB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            rw,
  input  logic [AW-1:0]   addr,
  input  logic [WB-1:0]   din,
  output wire  [WB-1:0]   dout,
  output logic            dout_oe,
  output logic [ROWS-1:0] word_lines,
  output logic [COLS-1:0] col_sel
);
  logic          rd_en, wr_en;
  logic [RB-1:0] row_idx;
  logic [CB-1:0] col_idx;
  logic [WB-1:0] acc_word;

  assign row_idx = addr[AW-1:CB];
  assign col_idx = addr[CB-1:0];
  assign rd_en   = cs & rw;
  assign wr_en   = cs & ~rw;

  onehot_dec #(.IW(RB)) u_row_dec (.en(cs), .idx(row_idx), .lines(word_lines));
  onehot_dec #(.IW(CB)) u_col_dec (.en(cs), .idx(col_idx), .lines(col_sel));

  cell_array #(.ROWS(ROWS), .COLS(COLS), .WB(WB)) u_array (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wl(word_lines), .csel(col_sel),
    .din(din), .rd_word(acc_word)
  );

  read_port #(.WB(WB)) u_port (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .acc_word(acc_word),
    .dout(dout), .dout_oe(dout_oe)
  );

  // R4: no decode activity without chip select
  a_r4_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (word_lines == '0 && col_sel == '0));
  // R2: one word line per access
  a_r2_wl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> $countones(word_lines) == 1);
  // R3: one column per access
  a_r3_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> $countones(col_sel) == 1);
  // R8: output released right after reset
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !dout_oe);
endmodule

// File: tb/grid_word_mem_tb.sv
module grid_word_mem_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // default 1024 x 16 instance
  logic        cs = 1'b0, rw = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] din = '0;
  wire  [15:0] dout;
  logic        dout_oe;
  logic [255:0] wl;
  logic [3:0]  cols;

  grid_word_mem u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .word_lines(wl), .col_sel(cols)
  );

  // narrow 4096 x 1 instance
  logic        ncs = 1'b0, nrw = 1'b1;
  logic [11:0] naddr = '0;
  logic [0:0]  ndin = '0;
  wire  [0:0]  ndout;
  logic        ndout_oe;
  logic [63:0] nwl;
  logic [63:0] ncols;

  grid_word_mem #(.NARROW(1'b1)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .cs(ncs), .rw(nrw), .addr(naddr), .din(ndin),
    .dout(ndout), .dout_oe(ndout_oe), .word_lines(nwl), .col_sel(ncols)
  );

  logic [15:0] model  [1024];
  logic        nmodel [4096];

  task automatic chk(input string req, input bit ok,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_wl(input logic c, input logic [9:0] a);
    logic [255:0] e = '0;
    if (c) e[a[9:2]] = 1'b1;   // R1 row field
    return e;
  endfunction

  function automatic logic [3:0] exp_col(input logic c, input logic [9:0] a);
    logic [3:0] e = '0;
    if (c) e[a[1:0]] = 1'b1;   // R1 column field
    return e;
  endfunction

  // one access on the wide port; decode checked before the edge, result after
  task automatic op(input logic c, input logic r, input logic [9:0] a,
                    input logic [15:0] d, input bit check_dec);
    @(negedge clk);
    cs = c; rw = r; addr = a; din = d;
    #1;
    if (check_dec) begin
      chk(c ? "R2 word lines" : "R4 word lines idle", wl == exp_wl(c, a), wl, exp_wl(c, a));
      chk(c ? "R3 column select" : "R4 column idle", cols == exp_col(c, a),
          {252'd0, cols}, {252'd0, exp_col(c, a)});
    end
    @(posedge clk);
    if (c && !r) model[a] = d;
    #1;
    if (c && r) begin
      chk("R5 read enable", dout_oe == 1'b1, {255'd0, dout_oe}, 256'd1);
      chk("R9 read data", dout == model[a], {240'd0, dout}, {240'd0, model[a]});
    end else if (c) begin
      chk("R6 write releases output", dout_oe == 1'b0, {255'd0, dout_oe}, 256'd0);
    end else begin
      chk("R4 idle releases output", dout_oe == 1'b0, {255'd0, dout_oe}, 256'd0);
    end
  endtask

  task automatic nop(input logic c, input logic r, input logic [11:0] a,
                     input logic d, input bit check);
    @(negedge clk);
    ncs = c; nrw = r; naddr = a; ndin = d;
    #1;
    if (check && c) begin
      chk("R10 narrow row line", nwl[a[11:6]] && $countones(nwl) == 1,
          {192'd0, nwl}, 256'd1 << a[11:6]);
      chk("R10 narrow column", ncols[a[5:0]] && $countones(ncols) == 1,
          {192'd0, ncols}, 256'd1 << a[5:0]);
    end
    @(posedge clk);
    if (c && !r) nmodel[a] = d;
    #1;
    if (check && c && r)
      chk("R10 narrow read", ndout_oe && ndout[0] == nmodel[a],
          {254'd0, ndout_oe, ndout[0]}, {254'd0, 1'b1, nmodel[a]});
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset output released", dout_oe == 1'b0, {255'd0, dout_oe}, 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 after reset", dout_oe == 1'b0, {255'd0, dout_oe}, 256'd0);

    // fill both arrays
    for (int i = 0; i < 1024; i++) op(1'b1, 1'b0, i[9:0], 16'($urandom), 1'b0);
    for (int i = 0; i < 4096; i++) nop(1'b1, 1'b0, i[11:0], 1'($urandom), 1'b0);

    // R7: neighbours in one row survive a write to one column
    for (int c = 0; c < 4; c++) op(1'b1, 1'b0, {8'd77, c[1:0]}, 16'h1000 + 16'(c), 1'b1);
    op(1'b1, 1'b0, {8'd77, 2'd2}, 16'hBEEF, 1'b1);
    for (int c = 0; c < 4; c++) begin
      op(1'b1, 1'b1, {8'd77, c[1:0]}, 16'h0, 1'b1);
      chk("R7 row neighbours kept", model[{8'd77, c[1:0]}] == ((c == 2) ? 16'hBEEF : 16'h1000 + 16'(c)),
          {240'd0, model[{8'd77, c[1:0]}]}, 256'd0);
    end

    // R4: write attempt with chip select low is ignored
    op(1'b1, 1'b0, 10'h3FF, 16'h5A5A, 1'b1);
    op(1'b0, 1'b0, 10'h3FF, 16'hFFFF, 1'b1);
    op(1'b1, 1'b1, 10'h3FF, 16'h0, 1'b1);
    chk("R4 ignored write", model[10'h3FF] == 16'h5A5A, {240'd0, model[10'h3FF]}, 256'h5A5A);

    // corner addresses, R1 fields
    op(1'b1, 1'b1, 10'h000, 16'h0, 1'b1);
    op(1'b1, 1'b1, 10'h003, 16'h0, 1'b1);
    op(1'b1, 1'b1, 10'h3FC, 16'h0, 1'b1);
    // R9: repeated reads do not disturb
    op(1'b1, 1'b1, 10'h155, 16'h0, 1'b1);
    op(1'b1, 1'b1, 10'h155, 16'h0, 1'b1);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic c = ($urandom_range(3) != 0);
      op(c, 1'($urandom), 10'($urandom), 16'($urandom), 1'b1);
    end

    // R10 narrow organisation
    nop(1'b1, 1'b0, 12'hFFF, 1'b1, 1'b1);
    nop(1'b1, 1'b1, 12'hFFF, 1'b0, 1'b1);
    nop(1'b1, 1'b0, 12'h040, 1'b0, 1'b1);
    nop(1'b1, 1'b1, 12'h040, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) nop(1'b1, 1'($urandom), 12'($urandom), 1'($urandom), 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule